// File: doc/BRIEF.md
# Configurable Sense Interrupt Controller

This block collects 32 interrupt sources into two processor request lines, one non-critical and one critical. Each source is sampled through a two-flop synchroniser. It can be sensed as a rising or falling edge, or as an active-high or active-low level. Every detected event sets a sticky status bit. The status bit is set even when the source is disabled.

Software configures the block through a small word-addressed register port. An enable register masks the status. A class register sends each enabled source to one of the two request lines. Software clears status bits by writing ones to them. A level source that is still active cannot be cleared. The two vector offsets have no function here and always read as zero.

Top module: `sense_irq_ctrl`

## Requirements
- R1: Source n (input `src_in[n]`) occupies bit 31-n of every register, so source 0 is the most significant bit. After reset the following hold: status, enable, class and trigger are all zero; polarity is all ones; both request outputs are low.
- R2: A trigger bit of 1 selects edge sensing and 0 selects level sensing. A polarity bit of 1 means a rising edge or an active-high level. A polarity bit of 0 means a falling edge or an active-low level.
- R3: Writing the status register (word address 0x0) clears each bit written as 1 and leaves each bit written as 0 untouched.
- R4: A level-sensed source whose input is at its active level keeps its status bit set through a clear, whether or not the source is enabled.
- R5: When a new edge event and a clear reach the same status bit in the same cycle, the bit stays set.
- R6: Status bits latch events while the source is disabled. Setting the enable bit (word address 0x2) later raises the request output on the next cycle.
- R7: Word address 0x6 reads as the bitwise AND of status and enable. Writes to that address have no effect.
- R8: Class bit 0 routes a source to `irq_nc` and class bit 1 routes it to `irq_crit` (class at word address 0x3). Each output is the registered OR of the enabled status bits of its class.
- R9: Polarity is at word address 0x4 and trigger at 0x5. Word addresses 0x7 and 0x8, and every unused address, read as zero and ignore writes.
- R10: An input change shows up in status on the third rising clock edge after the input changes. Read data appears one cycle after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | 32 | Raw interrupt inputs; index n is source n |
| wr_en | input | 1 | Single-cycle write strobe |
| addr | input | 4 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered from the address of the previous cycle |
| irq_nc | output | 1 | Non-critical request |
| irq_crit | output | 1 | Critical request |

## Verification
The assertions assume that the address and the write strobe are stable for the whole clock cycle in which they are sampled. They also assume that reset is released only after a few clock edges. The bench meets both by changing every input on the falling edge. The assertions make no assumption about `src_in`. To keep the expected values exact, the bench holds each source input stable for at least four cycles before it reads status. The one exception is the same-cycle collision case, where the bench lines up the write strobe with the third edge on purpose.

// File: rtl/sense_irq_ctrl.sv
module sense_irq_ctrl #(
  parameter int NSRC = 32,
  parameter int AW   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_in,
  input  logic            wr_en,
  input  logic [AW-1:0]   addr,
  input  logic [NSRC-1:0] wdata,
  output logic [NSRC-1:0] rdata,
  output logic            irq_nc,
  output logic            irq_crit
);
  localparam logic [AW-1:0] A_STAT = AW'(4'h0);
  localparam logic [AW-1:0] A_EN   = AW'(4'h2);
  localparam logic [AW-1:0] A_CLS  = AW'(4'h3);
  localparam logic [AW-1:0] A_POL  = AW'(4'h4);
  localparam logic [AW-1:0] A_TRIG = AW'(4'h5);
  localparam logic [AW-1:0] A_MSK  = AW'(4'h6);

  logic [NSRC-1:0] src_rev, sync1_q, sync2_q, prev_q;
  logic [NSRC-1:0] status_q, enable_q, class_q, pol_q, trig_q;
  logic [NSRC-1:0] act, prev_act, set_v, clr_v, masked;

  always_comb
    for (int n = 0; n < NSRC; n++) src_rev[NSRC-1-n] = src_in[n];

  assign act      = ~(sync2_q ^ pol_q);
  assign prev_act = ~(prev_q ^ pol_q);
  assign set_v    = (trig_q & act & ~prev_act) | (~trig_q & act);
  assign clr_v    = (wr_en && addr == A_STAT) ? wdata : '0;
  assign masked   = status_q & enable_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
      prev_q  <= '0;
    end else begin
      sync1_q <= src_rev;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      status_q <= '0;
      enable_q <= '0;
      class_q  <= '0;
      pol_q    <= '1;
      trig_q   <= '0;
    end else begin
      status_q <= (status_q & ~clr_v) | set_v;
      if (wr_en) begin
        if (addr == A_EN)   enable_q <= wdata;
        if (addr == A_CLS)  class_q  <= wdata;
        if (addr == A_POL)  pol_q    <= wdata;
        if (addr == A_TRIG) trig_q   <= wdata;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rdata    <= '0;
      irq_nc   <= 1'b0;
      irq_crit <= 1'b0;
    end else begin
      irq_nc   <= |(masked & ~class_q);
      irq_crit <= |(masked & class_q);
      case (addr)
        A_STAT:  rdata <= status_q;
        A_EN:    rdata <= enable_q;
        A_CLS:   rdata <= class_q;
        A_POL:   rdata <= pol_q;
        A_TRIG:  rdata <= trig_q;
        A_MSK:   rdata <= masked;
        default: rdata <= '0;
      endcase
    end
endmodule

module sense_irq_ctrl_chk #(
  parameter int NSRC = 32,
  parameter int AW   = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic [AW-1:0]   addr,
  input logic [NSRC-1:0] wdata,
  input logic [NSRC-1:0] rdata,
  input logic            irq_nc,
  input logic            irq_crit,
  input logic [NSRC-1:0] status,
  input logic [NSRC-1:0] enable,
  input logic [NSRC-1:0] cls,
  input logic [NSRC-1:0] trig,
  input logic [NSRC-1:0] act,
  input logic [NSRC-1:0] set_v
);
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(4'h0)) |=> ((status & $past(wdata & ~set_v)) == '0)); // R3
  AST_LEVEL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    ((~trig & act) != '0) |=> (($past(~trig & act) & ~status) == '0)); // R4
  AST_NO_REQ_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (enable == '0) |=> (!irq_nc && !irq_crit)); // R6
  AST_CRIT_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_crit |-> $past((status & enable & cls) != '0)); // R8
  AST_NC_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_nc |-> $past((status & enable & ~cls) != '0)); // R8
  AST_VECTOR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(addr) == AW'(4'h7) || $past(addr) == AW'(4'h8)) |-> (rdata == '0)); // R9
endmodule

bind sense_irq_ctrl sense_irq_ctrl_chk #(.NSRC(NSRC), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .rdata(rdata), .irq_nc(irq_nc), .irq_crit(irq_crit), .status(status_q),
  .enable(enable_q), .cls(class_q), .trig(trig_q), .act(act), .set_v(set_v));

// File: tb/sense_irq_ctrl_tb.sv
module sense_irq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_in = '0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_nc, irq_crit;
  int checks = 0, errors = 0;
  logic [31:0] rv, trig_sh, pol_sh;

  always #4 clk = ~clk;

  sense_irq_ctrl u_dut (.clk(clk), .rst_n(rst_n), .src_in(src_in), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_nc(irq_nc), .irq_crit(irq_crit));

  // {trigger, polarity, input before, input after, expected status}
  localparam logic [4:0] VEC [0:7] = '{
    5'b11011, 5'b11100, 5'b10101, 5'b10010,
    5'b01011, 5'b01000, 5'b00101, 5'b00110 };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; addr = 4'hE;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    @(negedge clk);
    d = rdata;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; src_in = '0; wr_en = 1'b0;
    idle(2);
    rst_n = 1'b1;
    idle(1);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    rd(4'h0, rv); chk("R1 status reset", rv, 32'h0);
    rd(4'h2, rv); chk("R1 enable reset", rv, 32'h0);
    rd(4'h3, rv); chk("R1 class reset", rv, 32'h0);
    rd(4'h5, rv); chk("R1 trigger reset", rv, 32'h0);
    rd(4'h4, rv); chk("R1 polarity reset", rv, 32'hFFFF_FFFF);
    chk("R1 outputs reset", {30'h0, irq_nc, irq_crit}, 32'h0);

    trig_sh = '0; pol_sh = '1;
    for (int e = 0; e < 8; e++) begin
      int s = e + 8;
      trig_sh[31-s] = VEC[e][4];
      pol_sh[31-s]  = VEC[e][3];
      src_in[s] = VEC[e][2];
      wr(4'h5, trig_sh);
      wr(4'h4, pol_sh);
      idle(4);
      wr(4'h0, 32'h1 << (31-s));
      src_in[s] = VEC[e][1];
      idle(4);
      rd(4'h0, rv);
      chk("R2 sense table", {31'h0, rv[31-s]}, {31'h0, VEC[e][0]});
    end

    // R10 status timing
    do_reset();
    wr(4'h5, 32'h8000_0000);
    @(negedge clk); src_in[0] = 1'b1; addr = 4'h0;
    idle(3);
    chk("R10 not before third edge", rdata, 32'h0);
    idle(1);
    chk("R10 set after third edge", rdata, 32'h8000_0000);

    // R3 selective clear
    @(negedge clk); src_in[1] = 1'b1;
    wr(4'h5, 32'hC000_0000);
    idle(4);
    wr(4'h0, 32'h8000_0000);
    rd(4'h0, rv); chk("R3 write-one clears only bit 31", rv, 32'h4000_0000);

    // R5 edge and clear in same cycle
    wr(4'h5, 32'hC400_0000);
    idle(2);
    @(negedge clk); src_in[5] = 1'b1;
    idle(1);
    @(negedge clk); wr_en = 1'b1; addr = 4'h0; wdata = 32'h0400_0000;
    @(negedge clk); wr_en = 1'b0;
    rd(4'h0, rv); chk("R5 event beats clear", rv & 32'h0400_0000, 32'h0400_0000);
    wr(4'h0, 32'h0400_0000);
    rd(4'h0, rv); chk("R3 later clear works", rv & 32'h0400_0000, 32'h0);

    // R4 level source stays set while active and masked
    @(negedge clk); src_in[3] = 1'b1;
    idle(4);
    wr(4'h0, 32'h1000_0000);
    rd(4'h0, rv); chk("R4 level clear blocked", rv & 32'h1000_0000, 32'h1000_0000);
    @(negedge clk); src_in[3] = 1'b0;
    idle(4);
    wr(4'h0, 32'h1000_0000);
    rd(4'h0, rv); chk("R4 level clears when inactive", rv & 32'h1000_0000, 32'h0);

    // R6 latching while disabled, R8 routing, R7 masked view
    wr(4'h0, 32'hFFFF_FFFF);
    wr(4'h5, 32'h2000_0000);
    @(negedge clk); src_in[2] = 1'b1;
    idle(4);
    chk("R6 no request while disabled", {30'h0, irq_nc, irq_crit}, 32'h0);
    rd(4'h6, rv); chk("R7 masked view while disabled", rv, 32'h0);
    wr(4'h2, 32'h2000_0000);
    idle(1);
    chk("R6 enable exposes pending", {30'h0, irq_nc, irq_crit}, 32'h2);
    rd(4'h6, rv); chk("R7 masked view", rv, 32'h2000_0000);
    wr(4'h3, 32'h2000_0000);
    idle(1);
    chk("R8 critical routing", {30'h0, irq_nc, irq_crit}, 32'h1);
    wr(4'h6, 32'h0);
    rd(4'h6, rv); chk("R7 write to masked ignored", rv, 32'h2000_0000);

    // R9 vector and unused offsets
    wr(4'h7, 32'hFFFF_FFFF);
    rd(4'h7, rv); chk("R9 vector reads zero", rv, 32'h0);
    wr(4'h8, 32'hFFFF_FFFF);
    rd(4'h8, rv); chk("R9 vector config reads zero", rv, 32'h0);
    wr(4'hF, 32'hFFFF_FFFF);
    rd(4'hF, rv); chk("R9 unused reads zero", rv, 32'h0);
    rd(4'h2, rv); chk("R9 writes elsewhere leave enable", rv, 32'h2000_0000);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule